// File: doc/BRIEF.md
# Processor Power-State Controller

This block follows the low-power state of one processor core. It watches a halt-instruction strobe, the wake events (SMI, INTR, NMI, INIT and a synchronous RESET), an active-low stop-clock request, a sleep request and a coherency probe request. From these it moves between Working (C0), Halt (C1), Stop Grant with a snoopable cache (C2), Sleep with a non-snoopable cache (S1) and a short Probe state. Moves between Halt and C2 pass through a one-cycle transition state in each direction.

The controller keeps two return records. One says whether C2 was entered from Halt or from Working, so that releasing stop-clock goes back to the right place. The other says whether Probe interrupted Halt or C2. A probe that arrives during S1 is held until the controller is back in C2. A probe that arrives during Working is left to the running core and does not change the state. A Probe lasts `PROBE_CYCLES` clocks. All outputs are registered and follow the state that was entered on the same clock edge: the state code, a core-clock enable, a snoop enable, a system-bus-connected flag and a one-cycle probe acknowledge.

Top module: `pwr_state_ctrl`

## Requirements
- R1: When `rst` or `wake_reset` is high at a clock edge, the next outputs are state code 0 (Working), `core_clk_en`=1, `snoop_en`=1, `bus_connected`=1 and `probe_ack`=0. The same edge clears both return records and any held probe. `wake_reset` overrides every other input in every state.
- R2: In Working (code 0), `halt_strobe` moves the controller to Halt (code 1), but only when `stpclk_n` is high.
- R3: In Halt, any of `wake_smi`, `wake_intr`, `wake_nmi` or `wake_init` moves the controller to Working. These wakes win over stop-clock and probe.
- R4: `stpclk_n` low in Working goes straight to C2 (code 2) and records Working as the return state. `stpclk_n` low in Halt goes to HaltToC2 (code 5) for exactly one cycle, then to C2, and records Halt as the return state.
- R5: `stpclk_n` high in C2 returns directly to Working when C2 was entered from Working. When C2 was entered from Halt, it goes to C2ToHalt (code 6) for exactly one cycle and then to Halt.
- R6: `probe_req` in Halt (when no wake and no stop-clock is present), or in C2 (when stop-clock stays low and there is no sleep request), enters Probe (code 4). Probe lasts `PROBE_CYCLES` cycles and then returns to the state it interrupted.
- R7: `probe_ack` is high for exactly one cycle, the first cycle after Probe ends, and is low at all other times.
- R8: `sleep_req` in C2, with stop-clock still low, enters S1 (code 3). S1 returns to C2 on the first edge where `sleep_req` is low. Within C2 the order of precedence is: stop-clock release, then sleep, then probe.
- R9: A `probe_req` seen in S1 is held and enters Probe from the next C2 cycle that is free of stop-clock release and sleep. The held probe is dropped only by entering Probe or by reset. A `probe_req` in Working does not change the state or the outputs.
- R10: `core_clk_en` is high only in codes 0 and 4. `bus_connected` is high only in codes 0, 4, 5 and 6. `snoop_en` is high in every code except 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| halt_strobe | input | 1 | Halt instruction executed |
| wake_smi | input | 1 | System-management interrupt wake |
| wake_intr | input | 1 | Maskable interrupt wake |
| wake_nmi | input | 1 | Non-maskable interrupt wake |
| wake_init | input | 1 | INIT wake |
| wake_reset | input | 1 | Synchronous core reset, highest priority |
| stpclk_n | input | 1 | Stop-clock request, active low |
| sleep_req | input | 1 | Request to enter S1 from C2 |
| probe_req | input | 1 | Incoming coherency probe |
| state_code | output | 3 | 0 C0, 1 C1, 2 C2, 3 S1, 4 Probe, 5 HaltToC2, 6 C2ToHalt |
| core_clk_en | output | 1 | Core clock running |
| snoop_en | output | 1 | Cache may be snooped |
| bus_connected | output | 1 | System bus connected |
| probe_ack | output | 1 | One-cycle pulse after a probe is serviced |

## Verification
Every input is sampled at a rising edge, and all five outputs show the resulting state just after that same edge. One cycle of latency therefore covers every result: a new state code, its flags and the acknowledge that follows a Probe. The two transition codes each appear for exactly one cycle, and Probe lasts `PROBE_CYCLES` cycles before the return state appears. The bench drives its inputs 2 ns after each rising edge. Its behavioural model steps on the same edge as the design, and the bench compares all outputs against the model 2 ns after every edge. This keeps each expected value aligned with the cycle in which it is due.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_WORK  = 3'd0,
    ST_HALT  = 3'd1,
    ST_SG    = 3'd2,
    ST_SLEEP = 3'd3,
    ST_PROBE = 3'd4,
    ST_H2SG  = 3'd5,
    ST_SG2H  = 3'd6
  } pstate_t;

  typedef struct packed {
    logic clk_en;
    logic snoop;
    logic bus;
  } pflags_t;
endpackage

// File: rtl/pwr_probe_timer.sv
module pwr_probe_timer #(
  parameter int PROBE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic in_probe,
  output logic done
);
  localparam int CW = (PROBE_CYCLES > 1) ? $clog2(PROBE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(PROBE_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done = in_probe && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !in_probe || done) cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end

  // R6: the count never runs past the last probe cycle
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  // R6: leaving probe always restarts the count
  p_cnt_restart_r6: assert property (@(posedge clk) disable iff (rst)
    !in_probe |=> cnt == '0);
endmodule

// File: rtl/pwr_next_state.sv
module pwr_next_state
  import pwr_pkg::*;
(
  input  pstate_t cur,
  input  logic    ret_sg_halt,
  input  pstate_t ret_probe,
  input  logic    pend,
  input  logic    probe_done,
  input  logic    halt_strobe,
  input  logic    any_wake,
  input  logic    stpclk_n,
  input  logic    sleep_req,
  input  logic    probe_req,
  output pstate_t nxt,
  output logic    ret_sg_we,
  output logic    ret_sg_d,
  output logic    ret_pr_we,
  output pstate_t ret_pr_d,
  output logic    pend_set,
  output logic    leave_probe
);
  always_comb begin
    nxt         = cur;
    ret_sg_we   = 1'b0;
    ret_sg_d    = 1'b0;
    ret_pr_we   = 1'b0;
    ret_pr_d    = ST_HALT;
    pend_set    = 1'b0;
    leave_probe = 1'b0;
    unique case (cur)
      ST_WORK: begin
        if (!stpclk_n) begin
          nxt       = ST_SG;
          ret_sg_we = 1'b1;
          ret_sg_d  = 1'b0;
        end else if (halt_strobe) begin
          nxt = ST_HALT;
        end
      end
      ST_HALT: begin
        if (any_wake)       nxt = ST_WORK;
        else if (!stpclk_n) nxt = ST_H2SG;
        else if (probe_req) begin
          nxt       = ST_PROBE;
          ret_pr_we = 1'b1;
          ret_pr_d  = ST_HALT;
        end
      end
      ST_H2SG: begin
        nxt       = ST_SG;
        ret_sg_we = 1'b1;
        ret_sg_d  = 1'b1;
      end
      ST_SG: begin
        if (stpclk_n)               nxt = ret_sg_halt ? ST_SG2H : ST_WORK;
        else if (sleep_req)         nxt = ST_SLEEP;
        else if (probe_req || pend) begin
          nxt       = ST_PROBE;
          ret_pr_we = 1'b1;
          ret_pr_d  = ST_SG;
        end
      end
      ST_SG2H:  nxt = ST_HALT;
      ST_SLEEP: begin
        pend_set = probe_req;
        if (!sleep_req) nxt = ST_SG;
      end
      ST_PROBE: begin
        if (probe_done) begin
          nxt         = ret_probe;
          leave_probe = 1'b1;
        end
      end
      default: nxt = ST_WORK;
    endcase
  end
endmodule

// File: rtl/pwr_flag_map.sv
module pwr_flag_map
  import pwr_pkg::*;
(
  input  pstate_t st,
  output pflags_t flags
);
  always_comb begin
    flags.clk_en = (st == ST_WORK) || (st == ST_PROBE);
    flags.snoop  = (st != ST_SLEEP);
    flags.bus    = (st == ST_WORK) || (st == ST_PROBE) ||
                   (st == ST_H2SG) || (st == ST_SG2H);
  end
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_pkg::*;
#(
  parameter int PROBE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       halt_strobe,
  input  logic       wake_smi,
  input  logic       wake_intr,
  input  logic       wake_nmi,
  input  logic       wake_init,
  input  logic       wake_reset,
  input  logic       stpclk_n,
  input  logic       sleep_req,
  input  logic       probe_req,
  output logic [2:0] state_code,
  output logic       core_clk_en,
  output logic       snoop_en,
  output logic       bus_connected,
  output logic       probe_ack
);
  pstate_t cur, nxt, ret_probe, ret_pr_d;
  logic    ret_sg_halt, pend;
  logic    ret_sg_we, ret_sg_d, ret_pr_we, pend_set, leave_probe;
  logic    probe_done, any_wake, clr;
  pflags_t nflags;

  assign any_wake = wake_smi | wake_intr | wake_nmi | wake_init;
  assign clr      = rst | wake_reset;

  pwr_probe_timer #(.PROBE_CYCLES(PROBE_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .in_probe(cur == ST_PROBE), .done(probe_done)
  );

  pwr_next_state u_next (
    .cur(cur), .ret_sg_halt(ret_sg_halt), .ret_probe(ret_probe), .pend(pend),
    .probe_done(probe_done), .halt_strobe(halt_strobe), .any_wake(any_wake),
    .stpclk_n(stpclk_n), .sleep_req(sleep_req), .probe_req(probe_req),
    .nxt(nxt), .ret_sg_we(ret_sg_we), .ret_sg_d(ret_sg_d),
    .ret_pr_we(ret_pr_we), .ret_pr_d(ret_pr_d), .pend_set(pend_set),
    .leave_probe(leave_probe)
  );

  pwr_flag_map u_flags (.st(nxt), .flags(nflags));

  always_ff @(posedge clk) begin
    if (clr) begin
      cur           <= ST_WORK;
      ret_sg_halt   <= 1'b0;
      ret_probe     <= ST_HALT;
      pend          <= 1'b0;
      state_code    <= ST_WORK;
      core_clk_en   <= 1'b1;
      snoop_en      <= 1'b1;
      bus_connected <= 1'b1;
      probe_ack     <= 1'b0;
    end else begin
      cur <= nxt;
      if (ret_sg_we) ret_sg_halt <= ret_sg_d;
      if (ret_pr_we) ret_probe   <= ret_pr_d;
      if (nxt == ST_PROBE) pend <= 1'b0;
      else if (pend_set)   pend <= 1'b1;
      state_code    <= nxt;
      core_clk_en   <= nflags.clk_en;
      snoop_en      <= nflags.snoop;
      bus_connected <= nflags.bus;
      probe_ack     <= leave_probe;
    end
  end

  // R1: a core reset always lands in Working
  p_reset_work_r1: assert property (@(posedge clk) disable iff (rst)
    wake_reset |=> state_code == 3'd0);
  // R4: HaltToC2 lasts one cycle and leads to C2
  p_h2sg_one_r4: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'd5 && !wake_reset) |=> state_code == 3'd2);
  // R5: C2ToHalt lasts one cycle and leads to Halt
  p_sg2h_one_r5: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'd6 && !wake_reset) |=> state_code == 3'd1);
  // R7: the acknowledge is a single-cycle pulse
  p_ack_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    probe_ack |=> !probe_ack);
  // R7: a probe that ends normally is acknowledged
  p_ack_after_probe_r7: assert property (@(posedge clk) disable iff (rst)
    ($fell(state_code == 3'd4) && !$past(wake_reset)) |-> probe_ack);
  // R8: S1 is entered only from C2
  p_sleep_from_sg_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(state_code == 3'd3) |-> $past(state_code) == 3'd2);
  // R10: the core clock runs only in Working or Probe
  p_clk_en_r10: assert property (@(posedge clk) disable iff (rst)
    core_clk_en |-> (state_code == 3'd0 || state_code == 3'd4));
  // R6: Probe is never entered from Working
  p_no_probe_from_work_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(state_code == 3'd4) |-> $past(state_code) != 3'd0);
endmodule

// File: tb/pwr_state_ctrl_bench.sv
module pwr_state_ctrl_bench;
  localparam int PC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt_strobe = 0, wake_smi = 0, wake_intr = 0, wake_nmi = 0, wake_init = 0;
  logic wake_reset = 0, stpclk_n = 1, sleep_req = 0, probe_req = 0;
  logic [2:0] state_code;
  logic core_clk_en, snoop_en, bus_connected, probe_ack;

  always #4 clk = ~clk;

  pwr_state_ctrl #(.PROBE_CYCLES(PC)) u_pwr_state_ctrl (
    .clk(clk), .rst(rst), .halt_strobe(halt_strobe), .wake_smi(wake_smi),
    .wake_intr(wake_intr), .wake_nmi(wake_nmi), .wake_init(wake_init),
    .wake_reset(wake_reset), .stpclk_n(stpclk_n), .sleep_req(sleep_req),
    .probe_req(probe_req), .state_code(state_code), .core_clk_en(core_clk_en),
    .snoop_en(snoop_en), .bus_connected(bus_connected), .probe_ack(probe_ack)
  );

  int vectors = 0;
  int errors  = 0;
  bit done_flag = 0;
  string tag = "R1";

  // behavioural reference model
  int m_state = 0, m_ret_pr = 1, m_cnt = 0;
  bit m_ret_halt = 0, m_pend = 0, m_ack = 0;

  always @(posedge clk) begin
    int n;
    bit a;
    if (rst || wake_reset) begin
      m_state = 0; m_ret_halt = 0; m_ret_pr = 1; m_pend = 0; m_cnt = 0; m_ack = 0;
    end else begin
      n = m_state; a = 0;
      case (m_state)
        0: if (!stpclk_n) begin n = 2; m_ret_halt = 0; end
           else if (halt_strobe) n = 1;
        1: if (wake_smi || wake_intr || wake_nmi || wake_init) n = 0;
           else if (!stpclk_n) n = 5;
           else if (probe_req) begin n = 4; m_ret_pr = 1; end
        5: begin n = 2; m_ret_halt = 1; end
        2: if (stpclk_n) n = m_ret_halt ? 6 : 0;
           else if (sleep_req) n = 3;
           else if (probe_req || m_pend) begin n = 4; m_ret_pr = 2; end
        6: n = 1;
        3: begin if (probe_req) m_pend = 1; if (!sleep_req) n = 2; end
        4: if (m_cnt == PC - 1) begin n = m_ret_pr; a = 1; end
        default: n = 0;
      endcase
      if (n == 4) m_pend = 0;
      m_cnt = (m_state == 4 && n == 4) ? m_cnt + 1 : 0;
      m_state = n;
      m_ack = a;
    end
  end

  task automatic compare();
    bit e_clk, e_snp, e_bus;
    e_clk = (m_state == 0 || m_state == 4);
    e_snp = (m_state != 3);
    e_bus = (m_state == 0 || m_state == 4 || m_state == 5 || m_state == 6);
    vectors++;
    if (state_code !== 3'(m_state) || core_clk_en !== e_clk || snoop_en !== e_snp ||
        bus_connected !== e_bus || probe_ack !== m_ack) begin
      errors++;
      $display("FAIL %s: got code=%0d clk=%b snp=%b bus=%b ack=%b, expected code=%0d clk=%b snp=%b bus=%b ack=%b",
               tag, state_code, core_clk_en, snoop_en, bus_connected, probe_ack,
               m_state, e_clk, e_snp, e_bus, m_ack);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      compare();
    end
  endtask

  task automatic idle_inputs();
    halt_strobe = 0; wake_smi = 0; wake_intr = 0; wake_nmi = 0; wake_init = 0;
    wake_reset = 0; stpclk_n = 1; sleep_req = 0; probe_req = 0;
  endtask

  task automatic to_halt();
    idle_inputs(); halt_strobe = 1; tick(); halt_strobe = 0; tick();
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got no end of run, expected completion");
    finish_run();
  end

  initial begin
    tag = "R1"; rst = 1; tick(3); rst = 0; tick(2);
    tag = "R9"; probe_req = 1; tick(3); probe_req = 0; tick();
    tag = "R2"; to_halt(); tick(2);
    tag = "R3";
    wake_smi = 1; tick(); wake_smi = 0; to_halt();
    wake_intr = 1; tick(); wake_intr = 0; to_halt();
    wake_nmi = 1; tick(); wake_nmi = 0; to_halt();
    wake_init = 1; stpclk_n = 0; probe_req = 1; tick(); idle_inputs(); tick();
    tag = "R4"; stpclk_n = 0; halt_strobe = 1; tick(4);
    tag = "R5"; stpclk_n = 1; halt_strobe = 0; tick(2);
    tag = "R4"; to_halt(); stpclk_n = 0; tick(4);
    tag = "R5"; stpclk_n = 1; tick(4);
    tag = "R6"; probe_req = 1; tick(); probe_req = 0; tick(PC + 2);
    tag = "R7"; stpclk_n = 0; tick(3); probe_req = 1; tick(); probe_req = 0; tick(PC + 2);
    tag = "R8"; sleep_req = 1; probe_req = 1; tick(3); probe_req = 0; tick(2);
    tag = "R9"; sleep_req = 0; tick(PC + 4);
    tag = "R8"; sleep_req = 1; tick(); stpclk_n = 1; tick(2); sleep_req = 0; tick(4);
    tag = "R1"; to_halt(); probe_req = 1; tick(2); probe_req = 0; wake_reset = 1; tick(); wake_reset = 0; tick(3);
    tag = "R10";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 100;
      halt_strobe = ($urandom % 4) == 0;
      wake_smi    = ($urandom % 23) == 0;
      wake_intr   = ($urandom % 29) == 0;
      wake_nmi    = ($urandom % 31) == 0;
      wake_init   = ($urandom % 37) == 0;
      wake_reset  = ($urandom % 97) == 0;
      if (r < 8) stpclk_n = ~stpclk_n;
      if (r > 90) sleep_req = ~sleep_req;
      probe_req   = ($urandom % 5) == 0;
      tick();
    end
    idle_inputs(); tick(PC + 4);
    finish_run();
  end
endmodule